// File: doc/BRIEF.md
# Programmable Vertical Clock Pattern Generator

This block produces six vertical clock waveforms for one line of an image sensor. A pixel counter restarts on each horizontal sync pulse. When the counter reaches a programmable start pixel, the selected pattern group begins. In that group, every output starts from its own programmed level and inverts at up to three programmed positions, or four in the extended groups. The pattern then repeats every programmed length, for a programmed number of repetitions. Once the last repetition is over, every output returns to its starting level.

A simple write port fills the storage for ten pattern groups and a few line-wide settings. Each group also carries two freeze windows. When a window's enable bit is set, all outputs hold their level inside that window and the pattern position stalls. When the window ends, the pattern carries on where it stopped. Every setting is captured into a working copy on the horizontal sync pulse, so a write made in the middle of a line never disturbs that line.

Top module: `vclk_pattern_gen`

## Requirements
- R1: After reset, `v_out` is all zero. All stored settings are zero, so a line started before any write keeps every output low.
- R2: A write address is split as {group[9:6], field[5:0]}.
  - Groups 0 to 9 use these fields:
    - toggle slot t of output o at field o*4+t;
    - starting level of output o at field 24+o, taken from data bit 0;
    - pattern length at field 32;
    - window A freeze and resume pixels at fields 33 and 34;
    - window B freeze and resume pixels at fields 35 and 36.
  - Group 15 holds the line-wide settings:
    - field 0: start pixel;
    - field 1: selected group;
    - field 2: repeat count, from data bits 7:0;
    - field 3: window enables, window A in bit 0 and window B in bit 1.
  - These writes have no effect: writes to groups 10 to 14, writes to unmapped fields, and a selected-group write with a value of 10 or more.
- R3: Pixel 0 is the cycle after the clock edge that samples `hsync` high. The output level for pixel p appears on `v_out` in the cycle after pixel p.
- R4: For pixels before the start pixel, each output drives its starting level.
- R5: Let q be the pattern position, counted from 0 at the start pixel. Each output is its starting level XOR the parity of its enabled toggle slots whose value is at most q and also below the pattern length. A slot equal to 0 inverts the output from the first position. A slot at or beyond the length never acts.
- R6: Toggle slot 3 (the fourth toggle) takes effect only when group 8 or 9 is selected. Writes to slot 3 in groups 0 to 7 are ignored.
- R7: Each repetition restarts at position 0 with the starting levels. After the requested number of repetitions, or when the repeat count or the length is 0, the outputs drive their starting levels for the rest of the line.
- R8: When a window's enable bit is set and its freeze pixel ≤ p < its resume pixel, all outputs hold their previous level and the pattern position does not advance. When the window ends, the remaining toggles follow unchanged.
- R9: A window whose enable bit is clear has no effect on the outputs.
- R10: Writes made during a line do not change that line's outputs. They take effect from the next `hsync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Line start pulse, one cycle high |
| cfg_we | input | 1 | Write strobe for the setting storage |
| cfg_addr | input | 10 | Group and field of the write |
| cfg_wdata | input | 12 | Write data |
| v_out | output | 6 | Vertical clock outputs |

## Verification
The assertions assume that `hsync` is a single-cycle pulse. They also assume that a line is shorter than the 4096-pixel counter range, so the pixel count never saturates in the middle of a pattern. Inside a line, a frozen pixel must be followed by a held output, and a stalled or finished pattern must show the starting levels. These checks only make sense if the working copy of the settings stays fixed between sync pulses.

The stimulus keeps every line well under 100 pixels and always pulses `hsync` for exactly one cycle. It never places a freeze window on pixel 0 when the start pixel is 0, since the held level would then belong to the previous line.

// File: rtl/vpg_pkg.sv
package vpg_pkg;
  // address split: group index above, field index below
  localparam int GRP_AW    = 4;
  localparam int FLD_W     = 6;
  localparam int TOG_SLOTS = 4;   // slot 3 is the extended (fourth) toggle

  localparam logic [GRP_AW-1:0] GRP_GLOBAL   = 4'hF;
  localparam logic [FLD_W-1:0]  FLD_POL_BASE = 6'd24;
  localparam logic [FLD_W-1:0]  FLD_LEN      = 6'd32;
  localparam logic [FLD_W-1:0]  FLD_WIN_BASE = 6'd33;  // frzA, resA, frzB, resB
  localparam logic [FLD_W-1:0]  FLD_G_START  = 6'd0;
  localparam logic [FLD_W-1:0]  FLD_G_SEL    = 6'd1;
  localparam logic [FLD_W-1:0]  FLD_G_REPS   = 6'd2;
  localparam logic [FLD_W-1:0]  FLD_G_MASK   = 6'd3;

  typedef enum logic [1:0] {
    SEQ_WAIT = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/vpg_cfg_store.sv
module vpg_cfg_store
  import vpg_pkg::*;
#(
  parameter int NUM_OUT    = 6,
  parameter int NUM_GRP    = 10,
  parameter int EXT_GRP_LO = 8,
  parameter int POS_W      = 12,
  parameter int REP_W      = 8
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          cfg_we,
  input  logic [GRP_AW+FLD_W-1:0]                       cfg_addr,
  input  logic [POS_W-1:0]                              cfg_wdata,
  input  logic                                          load,
  output logic [NUM_OUT-1:0]                            act_pol,
  output logic [NUM_OUT-1:0][TOG_SLOTS-1:0][POS_W-1:0]  act_tog,
  output logic                                          act_ext,
  output logic [POS_W-1:0]                              act_len,
  output logic [3:0][POS_W-1:0]                         act_win,
  output logic [POS_W-1:0]                              act_start,
  output logic [REP_W-1:0]                              act_reps,
  output logic [1:0]                                    act_mask
);
  localparam int SEL_W = $clog2(NUM_GRP);

  logic [GRP_AW-1:0] wr_grp;
  logic [FLD_W-1:0]  wr_fld;
  assign wr_grp = cfg_addr[FLD_W +: GRP_AW];
  assign wr_fld = cfg_addr[FLD_W-1:0];

  logic [NUM_GRP-1:0][NUM_OUT-1:0]                            pol_all;
  logic [NUM_GRP-1:0][NUM_OUT-1:0][TOG_SLOTS-1:0][POS_W-1:0]  tog_all;
  logic [NUM_GRP-1:0][POS_W-1:0]                              len_all;
  logic [NUM_GRP-1:0][3:0][POS_W-1:0]                         win_all;

  // ---------------- per-group shadow storage ----------------
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic grp_hit;
    assign grp_hit = cfg_we && (wr_grp == GRP_AW'(g));

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      logic pol_q, pol_we;
      assign pol_we = grp_hit && (wr_fld == FLD_POL_BASE + FLD_W'(o));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pol_q <= 1'b0;
        else if (pol_we) pol_q <= cfg_wdata[0];
      end
      assign pol_all[g][o] = pol_q;

      for (genvar t = 0; t < TOG_SLOTS; t++) begin : g_slot
        if (t < TOG_SLOTS-1 || g >= EXT_GRP_LO) begin : g_kept
          logic [POS_W-1:0] tog_q;
          logic             tog_we;
          assign tog_we = grp_hit && (wr_fld == FLD_W'(o*TOG_SLOTS + t));
          always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      tog_q <= '0;
            else if (tog_we) tog_q <= cfg_wdata;
          end
          assign tog_all[g][o][t] = tog_q;
        end else begin : g_absent
          assign tog_all[g][o][t] = '0;
        end
      end
    end

    logic [POS_W-1:0] len_q;
    logic             len_we;
    assign len_we = grp_hit && (wr_fld == FLD_LEN);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      len_q <= '0;
      else if (len_we) len_q <= cfg_wdata;
    end
    assign len_all[g] = len_q;

    for (genvar w = 0; w < 4; w++) begin : g_win
      logic [POS_W-1:0] win_q;
      logic             win_we;
      assign win_we = grp_hit && (wr_fld == FLD_WIN_BASE + FLD_W'(w));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      win_q <= '0;
        else if (win_we) win_q <= cfg_wdata;
      end
      assign win_all[g][w] = win_q;
    end
  end

  // ---------------- line-wide shadow settings ----------------
  logic             glb_hit;
  logic [POS_W-1:0] start_q;
  logic [SEL_W-1:0] sel_q;
  logic [REP_W-1:0] reps_q;
  logic [1:0]       mask_q;
  logic             start_we, sel_we, reps_we, mask_we;

  assign glb_hit  = cfg_we && (wr_grp == GRP_GLOBAL);
  assign start_we = glb_hit && (wr_fld == FLD_G_START);
  assign sel_we   = glb_hit && (wr_fld == FLD_G_SEL) && (cfg_wdata < POS_W'(NUM_GRP));
  assign reps_we  = glb_hit && (wr_fld == FLD_G_REPS);
  assign mask_we  = glb_hit && (wr_fld == FLD_G_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      sel_q   <= '0;
      reps_q  <= '0;
      mask_q  <= '0;
    end else begin
      if (start_we) start_q <= cfg_wdata;
      if (sel_we)   sel_q   <= cfg_wdata[SEL_W-1:0];
      if (reps_we)  reps_q  <= cfg_wdata[REP_W-1:0];
      if (mask_we)  mask_q  <= cfg_wdata[1:0];
    end
  end

  // ---------------- working copy, captured at line start ----------------
  logic [NUM_OUT-1:0]                            pol_d;
  logic [NUM_OUT-1:0][TOG_SLOTS-1:0][POS_W-1:0]  tog_d;
  logic                                          ext_d;
  logic [POS_W-1:0]                              len_d, start_d;
  logic [3:0][POS_W-1:0]                         win_d;
  logic [REP_W-1:0]                              reps_d;
  logic [1:0]                                    mask_d;

  always_comb begin
    pol_d   = act_pol;
    tog_d   = act_tog;
    ext_d   = act_ext;
    len_d   = act_len;
    win_d   = act_win;
    start_d = act_start;
    reps_d  = act_reps;
    mask_d  = act_mask;
    if (load) begin
      pol_d   = pol_all[sel_q];
      tog_d   = tog_all[sel_q];
      ext_d   = (sel_q >= SEL_W'(EXT_GRP_LO));
      len_d   = len_all[sel_q];
      win_d   = win_all[sel_q];
      start_d = start_q;
      reps_d  = reps_q;
      mask_d  = mask_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_pol   <= '0;
      act_tog   <= '0;
      act_ext   <= 1'b0;
      act_len   <= '0;
      act_win   <= '0;
      act_start <= '0;
      act_reps  <= '0;
      act_mask  <= '0;
    end else begin
      act_pol   <= pol_d;
      act_tog   <= tog_d;
      act_ext   <= ext_d;
      act_len   <= len_d;
      act_win   <= win_d;
      act_start <= start_d;
      act_reps  <= reps_d;
      act_mask  <= mask_d;
    end
  end
endmodule

// File: rtl/vpg_line_timer.sv
module vpg_line_timer #(
  parameter int POS_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hsync,
  input  logic [POS_W-1:0]       act_start,
  input  logic [3:0][POS_W-1:0]  act_win,
  input  logic [1:0]             act_mask,
  output logic                   started,
  output logic                   frozen
);
  logic [POS_W-1:0] pix_q, pix_d;
  logic [1:0]       in_win;

  always_comb begin
    if (hsync)              pix_d = '0;
    else if (pix_q == '1)   pix_d = pix_q;          // saturate at line end
    else                    pix_d = pix_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_q <= '1;
    else        pix_q <= pix_d;
  end

  assign started = (pix_q >= act_start);

  for (genvar k = 0; k < 2; k++) begin : g_win
    assign in_win[k] = act_mask[k]
                    && (pix_q >= act_win[2*k])
                    && (pix_q <  act_win[2*k+1]);
  end
  assign frozen = |in_win;
endmodule

// File: rtl/vpg_seq.sv
module vpg_seq
  import vpg_pkg::*;
#(
  parameter int POS_W = 12,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync,
  input  logic             started,
  input  logic             frozen,
  input  logic [POS_W-1:0] act_len,
  input  logic [REP_W-1:0] act_reps,
  output seq_state_e       state,
  output logic [POS_W-1:0] pos,
  output logic             empty
);
  seq_state_e       state_d;
  logic [POS_W-1:0] pos_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             advance;

  assign empty   = (act_len == '0) || (act_reps == '0);
  assign advance = !hsync && started && !frozen && (state != SEQ_DONE);

  always_comb begin
    state_d = state;
    pos_d   = pos;
    rep_d   = rep_q;
    if (hsync) begin
      state_d = SEQ_WAIT;
      pos_d   = '0;
      rep_d   = '0;
    end else if (advance) begin
      if (empty) begin
        state_d = SEQ_DONE;
      end else if (pos == act_len - 1'b1) begin
        pos_d = '0;
        if (rep_q == act_reps - 1'b1) begin
          state_d = SEQ_DONE;
        end else begin
          rep_d   = rep_q + 1'b1;
          state_d = SEQ_RUN;
        end
      end else begin
        pos_d   = pos + 1'b1;
        state_d = SEQ_RUN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_DONE;
      pos   <= '0;
      rep_q <= '0;
    end else begin
      state <= state_d;
      pos   <= pos_d;
      rep_q <= rep_d;
    end
  end
endmodule

// File: rtl/vpg_wave.sv
module vpg_wave
  import vpg_pkg::*;
#(
  parameter int POS_W = 12
) (
  input  logic                                pol,
  input  logic [TOG_SLOTS-1:0][POS_W-1:0]     tog,
  input  logic                                ext,
  input  logic [POS_W-1:0]                    pos,
  input  logic [POS_W-1:0]                    len,
  output logic                                level
);
  logic [TOG_SLOTS-1:0] passed;

  for (genvar t = 0; t < TOG_SLOTS; t++) begin : g_slot
    logic slot_on;
    if (t < TOG_SLOTS-1) begin : g_base
      assign slot_on = 1'b1;
    end else begin : g_extra
      assign slot_on = ext;
    end
    assign passed[t] = slot_on && (tog[t] <= pos) && (tog[t] < len);
  end

  assign level = pol ^ (^passed);
endmodule

// File: rtl/vclk_pattern_gen.sv
module vclk_pattern_gen
  import vpg_pkg::*;
#(
  parameter int NUM_OUT    = 6,
  parameter int NUM_GRP    = 10,
  parameter int EXT_GRP_LO = 8,
  parameter int POS_W      = 12,
  parameter int REP_W      = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hsync,
  input  logic                      cfg_we,
  input  logic [GRP_AW+FLD_W-1:0]   cfg_addr,
  input  logic [POS_W-1:0]          cfg_wdata,
  output logic [NUM_OUT-1:0]        v_out
);
  logic [NUM_OUT-1:0]                            act_pol;
  logic [NUM_OUT-1:0][TOG_SLOTS-1:0][POS_W-1:0]  act_tog;
  logic                                          act_ext;
  logic [POS_W-1:0]                              act_len, act_start;
  logic [3:0][POS_W-1:0]                         act_win;
  logic [REP_W-1:0]                              act_reps;
  logic [1:0]                                    act_mask;
  logic                                          started, frozen, empty;
  seq_state_e                                    state;
  logic [POS_W-1:0]                              pos;
  logic [NUM_OUT-1:0]                            wave_lvl, v_d;

  vpg_cfg_store #(
    .NUM_OUT(NUM_OUT), .NUM_GRP(NUM_GRP), .EXT_GRP_LO(EXT_GRP_LO),
    .POS_W(POS_W), .REP_W(REP_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .load(hsync),
    .act_pol(act_pol), .act_tog(act_tog), .act_ext(act_ext),
    .act_len(act_len), .act_win(act_win), .act_start(act_start),
    .act_reps(act_reps), .act_mask(act_mask)
  );

  vpg_line_timer #(.POS_W(POS_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .hsync(hsync),
    .act_start(act_start), .act_win(act_win), .act_mask(act_mask),
    .started(started), .frozen(frozen)
  );

  vpg_seq #(.POS_W(POS_W), .REP_W(REP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .started(started),
    .frozen(frozen), .act_len(act_len), .act_reps(act_reps),
    .state(state), .pos(pos), .empty(empty)
  );

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_wave
    vpg_wave #(.POS_W(POS_W)) u_wave (
      .pol(act_pol[o]), .tog(act_tog[o]), .ext(act_ext),
      .pos(pos), .len(act_len), .level(wave_lvl[o])
    );
  end

  always_comb begin
    if (hsync)                               v_d = v_out;     // line boundary
    else if (!started)                       v_d = act_pol;
    else if (frozen)                         v_d = v_out;
    else if (state == SEQ_DONE || empty)     v_d = act_pol;
    else                                     v_d = wave_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_out <= '0;
    else        v_out <= v_d;
  end
endmodule

// File: rtl/vpg_chk.sv
module vpg_chk
  import vpg_pkg::*;
#(
  parameter int NUM_OUT = 6,
  parameter int POS_W   = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hsync,
  input logic               started,
  input logic               frozen,
  input seq_state_e         state,
  input logic [POS_W-1:0]   pos,
  input logic [POS_W-1:0]   act_len,
  input logic [POS_W-1:0]   act_start,
  input logic [NUM_OUT-1:0] act_pol,
  input logic [NUM_OUT-1:0] v_out
);
  // R4
  prestart_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync && !started) |=> (v_out == act_pol));

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync && started && frozen) |=> $stable(v_out));

  // R8
  freeze_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync && frozen) |=> $stable(pos));

  // R7
  finished_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync && started && !frozen && state == SEQ_DONE) |=> (v_out == act_pol));

  // R7
  pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_RUN) |-> (pos < act_len));

  // R10
  line_cfg_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync |=> ($stable(act_pol) && $stable(act_len) && $stable(act_start)));
endmodule

bind vclk_pattern_gen vpg_chk #(.NUM_OUT(NUM_OUT), .POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .started(started),
  .frozen(frozen), .state(state), .pos(pos), .act_len(act_len),
  .act_start(act_start), .act_pol(act_pol), .v_out(v_out)
);

// File: tb/vclk_pattern_gen_bench.sv
module vclk_pattern_gen_bench;
  localparam int NO = 6;
  localparam int NG = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync = 1'b0;
  logic       cfg_we = 1'b0;
  logic [9:0] cfg_addr = '0;
  logic [11:0] cfg_wdata = '0;
  logic [NO-1:0] v_out;

  always #4 clk = ~clk;   // 125 MHz

  vclk_pattern_gen u_vclk_pattern_gen (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .v_out(v_out)
  );

  int checks = 0;
  int errors = 0;

  // shadow view of the settings, kept from the requirements
  logic [NO-1:0] s_pol [NG];
  int s_tog [NG][NO][4];
  int s_len [NG];
  int s_win [NG][4];
  int s_start, s_sel, s_reps;
  logic [1:0] s_mask;

  // settings of the current line
  logic [NO-1:0] m_pol;
  int m_tog [NO][4];
  int m_len, m_start, m_reps, m_e, pix_idx;
  int m_win [4];
  logic [1:0] m_mask;
  bit m_ext;
  logic [NO-1:0] m_v = '0;

  bit live = 0;
  string live_tag = "";

  task automatic check_pixel(input string tag);
    int p, q;
    bit frz, par;
    p = pix_idx;
    frz = (m_mask[0] && p >= m_win[0] && p < m_win[1]) ||
          (m_mask[1] && p >= m_win[2] && p < m_win[3]);
    if (p < m_start) m_v = m_pol;
    else if (!frz) begin
      if (m_len == 0 || m_e >= m_reps * m_len) m_v = m_pol;
      else begin
        q = m_e % m_len;
        for (int o = 0; o < NO; o++) begin
          par = 0;
          for (int t = 0; t < 4; t++)
            if ((t < 3 || m_ext) && m_tog[o][t] <= q && m_tog[o][t] < m_len) par = ~par;
          m_v[o] = m_pol[o] ^ par;
        end
      end
      m_e++;
    end
    checks++;
    if (v_out !== m_v) begin
      errors++;
      $display("FAIL %s pixel %0d got %b expected %b", tag, p, v_out, m_v);
    end
    pix_idx++;
  endtask

  task automatic put(input int g, input int f, input int d);
    cfg_addr  = {g[3:0], f[5:0]};
    cfg_wdata = d[11:0];
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we    = 1'b0;
    if (live) check_pixel(live_tag);
  endtask

  task automatic set_tog(input int g, input int o, input int t, input int v);
    if (t < 3 || g >= 8) s_tog[g][o][t] = v;   // R6: slot 3 absent below group 8
    put(g, o*4 + t, v);
  endtask

  task automatic set_pol(input int g, input logic [NO-1:0] b);
    s_pol[g] = b;
    for (int o = 0; o < NO; o++) put(g, 24 + o, int'(b[o]));
  endtask

  task automatic set_len(input int g, input int v);
    s_len[g] = v; put(g, 32, v);
  endtask

  task automatic set_win(input int g, input int w, input int v);
    s_win[g][w] = v; put(g, 33 + w, v);
  endtask

  task automatic set_glob(input int f, input int v);
    case (f)
      0: s_start = v;
      1: if (v < NG) s_sel = v;
      2: s_reps = v & 255;
      3: s_mask = v[1:0];
      default: ;
    endcase
    put(15, f, v);
  endtask

  task automatic start_line();
    hsync = 1'b1;
    @(negedge clk);
    hsync = 1'b0;
    m_pol = s_pol[s_sel];
    for (int o = 0; o < NO; o++)
      for (int t = 0; t < 4; t++) m_tog[o][t] = s_tog[s_sel][o][t];
    m_len = s_len[s_sel];
    for (int w = 0; w < 4; w++) m_win[w] = s_win[s_sel][w];
    m_start = s_start; m_reps = s_reps; m_mask = s_mask;
    m_ext = (s_sel >= 8);
    m_e = 0; pix_idx = 0;
  endtask

  task automatic step(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_pixel(tag);
    end
  endtask

  task automatic base_toggles(input int g);
    for (int o = 0; o < NO; o++) begin
      set_tog(g, o, 0, 2 + o);
      set_tog(g, o, 1, 6 + o);
      set_tog(g, o, 2, 10 + o);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    for (int g = 0; g < NG; g++) begin
      s_pol[g] = '0; s_len[g] = 0;
      for (int w = 0; w < 4; w++) s_win[g][w] = 0;
      for (int o = 0; o < NO; o++)
        for (int t = 0; t < 4; t++) s_tog[g][o][t] = 0;
    end
    s_start = 0; s_sel = 0; s_reps = 0; s_mask = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (v_out !== '0) begin
      errors++; $display("FAIL R1 reset got %b expected %b", v_out, 6'b0);
    end
    start_line();
    step(12, "R1 unprogrammed line");

    // R2 R3 R4 R5: basic pattern, single repetition
    set_pol(0, 6'b101010);
    base_toggles(0);
    set_len(0, 20);
    set_glob(0, 5);
    set_glob(1, 0);
    set_glob(2, 1);
    set_glob(3, 0);
    start_line();
    step(40, "R5 basic");

    // R7 R5: sweep of start, length and repeat count
    for (int st = 0; st < 4; st += 3)
      for (int li = 0; li < 3; li++)
        for (int rp = 1; rp <= 3; rp++) begin
          int ln;
          ln = (li == 0) ? 4 : (li == 1) ? 7 : 16;
          set_len(0, ln);
          set_glob(0, st);
          set_glob(2, rp);
          start_line();
          step(st + rp*ln + 6, "R7 repeat sweep");
        end

    // R6: fourth slot in an extended group, slot at 0, slot past length
    set_pol(8, 6'b010011);
    base_toggles(8);
    set_tog(8, 0, 0, 0);
    set_tog(8, 1, 2, 30);
    for (int o = 0; o < NO; o++) set_tog(8, o, 3, 14 + o);
    set_len(8, 24);
    set_glob(1, 8);
    set_glob(0, 2);
    set_glob(2, 2);
    start_line();
    step(60, "R6 extended group");

    // R6: fourth slot written in group 3 has no effect
    set_pol(3, 6'b010011);
    base_toggles(3);
    for (int o = 0; o < NO; o++) set_tog(3, o, 3, 14 + o);
    set_len(3, 24);
    set_glob(1, 3);
    start_line();
    step(60, "R6 base group ignores slot 3");

    // R8 R9: freeze windows with each enable combination
    set_win(8, 0, 8);  set_win(8, 1, 12);
    set_win(8, 2, 20); set_win(8, 3, 23);
    set_glob(1, 8);
    for (int mk = 0; mk < 4; mk++) begin
      set_glob(3, mk);
      start_line();
      step(66, (mk == 0) ? "R9 windows disabled" : "R8 freeze window");
    end
    set_glob(3, 0);

    // R10: writes during a line wait for the next sync
    set_glob(1, 0);
    set_len(0, 20);
    set_glob(0, 3);
    set_glob(2, 2);
    start_line();
    step(10, "R10 before write");
    live = 1; live_tag = "R10 mid-line write";
    set_len(0, 9);
    set_pol(0, 6'b000111);
    set_glob(0, 1);
    set_glob(2, 3);
    live = 0;
    step(30, "R10 old settings kept");
    start_line();
    step(40, "R10 new settings");

    // R2: ignored writes (missing group, bad select, unmapped field)
    put(12, 32, 5);
    put(15, 1, 11);
    put(0, 40, 7);
    start_line();
    step(40, "R2 ignored writes");

    // R7: zero repeat count keeps starting levels
    set_glob(2, 0);
    start_line();
    step(20, "R7 zero repeats");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule